// File: doc/BRIEF.md
# Watermark-Interrupt Serial Transceiver

This block is an asynchronous serial transmitter and receiver that sits behind a small word-addressed register port. Software queues bytes into a transmit FIFO. A shifter sends them as 8-bit frames with one or two stop bits. An oversampling receiver collects incoming frames into a receive FIFO of the same depth, and software reads them back one word at a time. The bit period is programmed as a clock divisor. The register holds the bit period in clock cycles minus one, so software writes ceil(fclk/baud) - 1.

Interrupts follow FIFO fill levels rather than individual bytes. The transmit condition is pending while the transmit FIFO holds fewer bytes than its watermark. The receive condition is pending while the receive FIFO holds more bytes than its watermark. Each condition has its own enable, and the single interrupt line is the OR of the enabled conditions. No status bit shows that the shifter has gone idle. An empty transmit FIFO can still have one frame on the wire.

The register port accepts one access per cycle (`req_ready` is always high). Read data returns one cycle after the request, qualified by `rsp_valid`. Word addresses are: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor.

Top module: `wmark_uart`

## Requirements
- R1: An idle transmit line is high. A frame is one low start bit, then 8 data bits least-significant first, then high stop bits. Each bit lasts divisor+1 clock cycles. Bytes leave in write order, and a byte waiting in the FIFO starts one cycle after the previous frame ends.
- R2: Bit 0 of transmit control (address 2) holds the stop-bit count minus one. With 0, back-to-back frames start 10 bit periods plus one cycle apart. With 1, they start 11 bit periods plus one cycle apart.
- R3: Reading address 0 returns the transmit-FIFO-full flag in bit 31, with all other bits zero. A write to address 0 pushes bits 7:0. While the FIFO (depth 8) is full, such a write is dropped.
- R4: Reading address 1 returns the oldest received byte in bits 7:0 and pops it. If the FIFO is empty, the read returns bit 31 set and removes nothing.
- R5: The receiver takes 16 samples per bit, with one sample every (divisor+1)/16 cycles. It stores correctly framed bytes in arrival order. This holds exactly when divisor+1 is a multiple of 16, and the fastest line rate is fclk/16.
- R6: A received frame whose stop bit samples low is discarded.
- R7: The start bit is confirmed at its middle. A low pulse shorter than half a bit produces no byte.
- R8: Interrupt-pending bit 0 (address 5) is set while the transmit FIFO count is below the transmit watermark, held in bits 19:16 of address 2.
- R9: Interrupt-pending bit 1 is set while the receive FIFO count is above the receive watermark, held in bits 19:16 of address 3.
- R10: `irq` is high exactly when a pending bit is set whose enable is set. Enable bit 0 (transmit) and bit 1 (receive) are at address 4.
- R11: After reset the following hold: `txd` is high and `irq` is low; pending, enables, watermarks and stop bit are zero; the divisor reads 15; and both FIFOs are empty.
- R12: A frame that completes while the receive FIFO (depth 8) is full is dropped, and the stored bytes are kept.
- R13: The divisor at address 6 reads back as written, and a new value sets the bit period of both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle:
- FIFO occupancy never exceeds the depth.
- A write to a full transmit FIFO leaves its count unchanged.
- A receive read on an empty FIFO leaves it empty.
- The shifter loads a byte only when idle, and every frame begins with a low start bit.
- The interrupt stays low while no enable is set.

The bench scenarios cover what needs whole frames on the wire:
- bit order and timing, and the frame spacing that reveals one or two stop bits;
- rejection of bad stop bits and of short start glitches;
- drop behaviour of a full receive FIFO;
- how the watermark pending bits follow the fill levels as bytes drain and arrive.

// File: rtl/wmark_uart_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the watermark serial transceiver: register word
// addresses and the receiver state encoding.
package wmark_uart_pkg;

    typedef enum logic [2:0] {
        RA_TXDATA  = 3'd0,
        RA_RXDATA  = 3'd1,
        RA_TXCTL   = 3'd2,
        RA_RXCTL   = 3'd3,
        RA_IRQEN   = 3'd4,
        RA_IRQPEND = 3'd5,
        RA_DIVISOR = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_e;

    localparam int WM_LSB = 16;

endpackage

// File: rtl/wu_fifo.sv
`timescale 1ns/1ps
// Synchronous show-ahead FIFO. The head entry is visible on rdata while the
// FIFO is not empty. A push while full and a pop while empty are ignored.
// Assumes a single clock and DEPTH >= 2.
module wu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CFULL);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/wu_tx.sv
`timescale 1ns/1ps
// Transmit shifter. When idle and the FIFO has data, it pops one byte and
// sends start, 8 data bits LSB first and 1 or 2 stop bits. Each bit lasts
// div+1 cycles. The stop-bit count is latched when the frame loads.
module wu_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             two_stop,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    output logic             fifo_pop,
    output logic             txd,
    output logic             busy
);
    logic [10:0]      shreg;
    logic [3:0]       bits_left;
    logic [DIV_W-1:0] bcnt;

    assign fifo_pop = !busy && !fifo_empty;
    assign txd      = busy ? shreg[0] : 1'b1;

    // Frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            bcnt      <= '0;
            busy      <= 1'b0;
        end else if (!busy) begin
            if (!fifo_empty) begin
                shreg     <= {2'b11, fifo_data, 1'b0};
                bits_left <= two_stop ? 4'd11 : 4'd10;
                bcnt      <= '0;
                busy      <= 1'b1;
            end
        end else if (bcnt == div) begin
            bcnt      <= '0;
            shreg     <= {1'b1, shreg[10:1]};
            bits_left <= bits_left - 4'd1;
            if (bits_left == 4'd1) busy <= 1'b0;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wu_rx.sv
`timescale 1ns/1ps
// Oversampling receiver. It synchronizes rxd and generates 16 sample ticks
// per bit, one every (div+1)/16 cycles. It confirms the start bit on the
// 8th tick, samples data and stop bits every 16 ticks after that, and pulses
// push for a frame whose stop bit is high.
module wu_rx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             push,
    output logic [7:0]       data
);
    import wmark_uart_pkg::*;

    rx_state_e      state;
    logic           sync1, sync2;
    logic [DIV_W:0] period, ps_top, pcnt;
    logic [3:0]     tcnt;
    logic [2:0]     bidx;
    logic           tick;

    assign period = ({1'b0, div} + 1'b1) >> 4;
    assign ps_top = (period == '0) ? '0 : period - 1'b1;
    assign tick   = (pcnt == ps_top);

    // Two-stage synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
        end
    end

    // Frame state machine with sample tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RXS_IDLE;
            pcnt  <= '0;
            tcnt  <= '0;
            bidx  <= '0;
            data  <= '0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (state == RXS_IDLE) begin
                pcnt <= '0;
                tcnt <= '0;
                bidx <= '0;
                if (!sync2) state <= RXS_START;
            end else begin
                pcnt <= tick ? '0 : pcnt + 1'b1;
                if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    case (state)
                        RXS_START: if (tcnt == 4'd7) begin
                            tcnt  <= '0;
                            state <= sync2 ? RXS_IDLE : RXS_DATA;
                        end
                        RXS_DATA: if (tcnt == 4'd15) begin
                            data <= {sync2, data[7:1]};
                            bidx <= bidx + 3'd1;
                            if (bidx == 3'd7) state <= RXS_STOP;
                        end
                        RXS_STOP: if (tcnt == 4'd15) begin
                            push  <= sync2;
                            state <= RXS_IDLE;
                        end
                        default: state <= RXS_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wmark_uart.sv
`timescale 1ns/1ps
// Serial transceiver top. It holds the register file, both FIFOs, the
// transmit shifter, the oversampling receiver and the watermark interrupt
// logic. The register port accepts one access per cycle. Read data is
// registered and returned one cycle later.
module wmark_uart #(
    parameter int DEPTH     = 8,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 15,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [2:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        txd,
    input  logic        rxd,
    output logic        irq
);
    import wmark_uart_pkg::*;

    logic             two_stop;
    logic [CW-1:0]    tx_wm, rx_wm;
    logic [1:0]       ie;
    logic [DIV_W-1:0] div;

    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    tx_head, rx_head, rx_byte;
    logic          tx_push, tx_pop, tx_busy, rx_push, rx_pop;
    logic          wr_en, rd_en;
    logic [1:0]    pend;
    logic [31:0]   rd_mux;

    assign req_ready = 1'b1;
    assign wr_en     = req_valid && req_write;
    assign rd_en     = req_valid && !req_write;
    assign tx_push   = wr_en && (req_addr == RA_TXDATA);
    assign rx_pop    = rd_en && (req_addr == RA_RXDATA);

    assign pend[0] = (tx_count < tx_wm);
    assign pend[1] = (rx_count > rx_wm);
    assign irq     = |(pend & ie);

    wu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk, .rst_n, .push(tx_push), .wdata(req_wdata[7:0]), .pop(tx_pop),
        .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    wu_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk, .rst_n, .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    wu_tx #(.DIV_W(DIV_W)) u_tx (
        .clk, .rst_n, .div, .two_stop, .fifo_empty(tx_empty),
        .fifo_data(tx_head), .fifo_pop(tx_pop), .txd, .busy(tx_busy)
    );

    wu_rx #(.DIV_W(DIV_W)) u_rx (
        .clk, .rst_n, .div, .rxd, .push(rx_push), .data(rx_byte)
    );

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            two_stop <= 1'b0;
            tx_wm    <= '0;
            rx_wm    <= '0;
            ie       <= '0;
            div      <= DIV_W'(DIV_RESET);
        end else if (wr_en) begin
            case (req_addr)
                RA_TXCTL: begin
                    two_stop <= req_wdata[0];
                    tx_wm    <= req_wdata[WM_LSB +: CW];
                end
                RA_RXCTL:   rx_wm <= req_wdata[WM_LSB +: CW];
                RA_IRQEN:   ie    <= req_wdata[1:0];
                RA_DIVISOR: div   <= req_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (req_addr)
            RA_TXDATA: rd_mux[31] = tx_full;
            RA_RXDATA: begin
                rd_mux[31]  = rx_empty;
                rd_mux[7:0] = rx_empty ? 8'h00 : rx_head;
            end
            RA_TXCTL: begin
                rd_mux[0]             = two_stop;
                rd_mux[WM_LSB +: CW]  = tx_wm;
            end
            RA_RXCTL:   rd_mux[WM_LSB +: CW] = rx_wm;
            RA_IRQEN:   rd_mux[1:0] = ie;
            RA_IRQPEND: rd_mux[1:0] = pend;
            RA_DIVISOR: rd_mux[DIV_W-1:0] = div;
            default: ;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/wmark_uart_chk.sv
`timescale 1ns/1ps
// Property checker for the serial transceiver, bound into every instance
// of the top module. It observes the FIFO occupancy, shifter state and
// register port.
module wmark_uart_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [2:0]    req_addr,
    input logic [CW-1:0] tx_count,
    input logic          tx_full,
    input logic          tx_pop,
    input logic          tx_busy,
    input logic          txd,
    input logic [CW-1:0] rx_count,
    input logic          rx_push,
    input logic [1:0]    ie,
    input logic          irq
);
    a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 3'd0 && tx_full && !tx_pop)
        |=> tx_count == $past(tx_count));

    a_r1_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_busy);

    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    a_r4_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 3'd1 && rx_count == '0 && !rx_push)
        |=> rx_count == '0);

    a_r12_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);
endmodule

bind wmark_uart wmark_uart_chk #(.DEPTH(DEPTH)) u_chk (
    .clk, .rst_n, .req_valid, .req_write, .req_addr,
    .tx_count, .tx_full, .tx_pop, .tx_busy, .txd,
    .rx_count, .rx_push, .ie, .irq
);

// File: tb/wmark_uart_test.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks queue the expected transmit and receive
// bytes. A line monitor decodes txd and register reads drain the receive
// side, each comparing against the queues.
module wmark_uart_test;
    localparam int DEPTH = 8;
    localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_TXC = 3'd2,
                           A_RXC = 3'd3, A_IE = 3'd4, A_IP = 3'd5, A_DIV = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, txd, irq;
    logic [31:0] rsp_rdata;
    logic        rxd = 1'b1;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int bitp = 16;
    int mon_gap = 0;
    bit mon_have = 0;
    bit done = 0;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];
    int rx_model = 0;

    wmark_uart #(.DEPTH(DEPTH), .DIV_W(16), .DIV_RESET(15)) uut (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
        .req_wdata, .rsp_valid, .rsp_rdata, .txd, .rxd, .irq
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        d = rsp_rdata;
    endtask

    task automatic send_byte(input logic [7:0] b);
        tx_exp.push_back(b);
        reg_wr(A_TXD, {24'h0, b});
    endtask

    task automatic wait_tx_drain();
        int guard = 0;
        while (tx_exp.size() != 0 && guard < 20000) begin
            @(negedge clk); guard++;
        end
        repeat (2 * bitp) @(negedge clk);
    endtask

    task automatic line_rx(input logic [7:0] b, input bit good_stop);
        rxd = 1'b0;
        repeat (bitp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitp) @(negedge clk);
        end
        rxd = good_stop;
        repeat (bitp) @(negedge clk);
        rxd = 1'b1;
        if (good_stop && rx_model < DEPTH) begin
            rx_exp.push_back(b);
            rx_model++;
        end
        repeat (good_stop ? 2 : bitp) @(negedge clk);
    endtask

    task automatic rx_read_check(input string req);
        logic [31:0] d;
        reg_rd(A_RXD, d);
        if (rx_exp.size() != 0) begin
            logic [7:0] e;
            e = rx_exp.pop_front();
            rx_model--;
            check(d[31] == 1'b0 && d[7:0] == e, req, d, {24'h0, e});
        end else begin
            check(d[31] == 1'b1, req, d, 32'h8000_0000);
        end
    endtask

    // Line monitor: decodes transmitted frames and compares with the queue (R1).
    initial begin
        logic prev;
        logic [7:0] got;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                if (mon_have) mon_gap = cyc - mon_gap;
                else mon_gap = cyc;
                mon_have = 1;
                repeat (bitp / 2) @(negedge clk);
                check(txd == 1'b0, "R1 start bit", {31'h0, txd}, 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bitp) @(negedge clk);
                    got[i] = txd;
                end
                repeat (bitp) @(negedge clk);
                check(txd == 1'b1, "R1 stop bit", {31'h0, txd}, 32'h1);
                if (tx_exp.size() == 0) begin
                    check(1'b0, "R1 unexpected frame", {24'h0, got}, 32'h0);
                end else begin
                    logic [7:0] e;
                    e = tx_exp.pop_front();
                    check(got == e, "R1 tx byte", {24'h0, got}, {24'h0, e});
                end
                prev = 1'b1;
            end else begin
                prev = txd;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(txd == 1'b1, "R11 txd idle", {31'h0, txd}, 32'h1);
        check(irq == 1'b0, "R11 irq low", {31'h0, irq}, 32'h0);
        reg_rd(A_IP, d);  check(d == 32'h0, "R11 pending", d, 32'h0);
        reg_rd(A_DIV, d); check(d == 32'd15, "R11 divisor", d, 32'd15);
        reg_rd(A_TXD, d); check(d == 32'h0, "R11 R3 not full", d, 32'h0);
        reg_rd(A_TXC, d); check(d == 32'h0, "R11 txctl", d, 32'h0);
        rx_read_check("R11 R4 rx empty");

        // R1: single frames, various patterns
        send_byte(8'hA5); wait_tx_drain();
        send_byte(8'h01); send_byte(8'hFE); wait_tx_drain();

        // R1 R2: one stop bit spacing
        mon_have = 0;
        send_byte(8'h3C); send_byte(8'hC3); wait_tx_drain();
        check(mon_gap == 10 * bitp + 1, "R2 one-stop gap", mon_gap, 10 * bitp + 1);

        // R2: two stop bits
        reg_wr(A_TXC, 32'h1);
        mon_have = 0;
        send_byte(8'h55); send_byte(8'hAA); wait_tx_drain();
        check(mon_gap == 11 * bitp + 1, "R2 two-stop gap", mon_gap, 11 * bitp + 1);
        reg_wr(A_TXC, 32'h0);

        // R3: overfill: 10 back-to-back writes, first 9 accepted
        for (int i = 0; i < 10; i++) begin
            if (i < 9) tx_exp.push_back(8'h10 + 8'(i));
            reg_wr(A_TXD, 32'h10 + i);
        end
        reg_rd(A_TXD, d); check(d == 32'h8000_0000, "R3 full flag", d, 32'h8000_0000);
        wait_tx_drain();
        reg_rd(A_TXD, d); check(d == 32'h0, "R3 full cleared", d, 32'h0);

        // R8 R10: transmit watermark 2
        reg_wr(A_TXC, 32'h2 << 16);
        reg_rd(A_IP, d); check(d[0] == 1'b1, "R8 tx pending when empty", d, 32'h1);
        reg_wr(A_IE, 32'h1);
        @(negedge clk); check(irq == 1'b1, "R10 tx irq", {31'h0, irq}, 32'h1);
        send_byte(8'h61); send_byte(8'h62); send_byte(8'h63);
        reg_rd(A_IP, d); check(d[0] == 1'b0, "R8 tx not pending at 2", d, 32'h0);
        check(irq == 1'b0, "R10 irq follows", {31'h0, irq}, 32'h0);
        wait_tx_drain();
        reg_rd(A_IP, d); check(d[0] == 1'b1, "R8 pending after drain", d, 32'h1);
        reg_wr(A_IE, 32'h0);
        @(negedge clk); check(irq == 1'b0, "R10 masked", {31'h0, irq}, 32'h0);
        reg_wr(A_TXC, 32'h0);
        reg_rd(A_IP, d); check(d[0] == 1'b0, "R8 wm zero", d, 32'h0);

        // R5: receive bytes in order
        line_rx(8'hA5, 1'b1); line_rx(8'h3C, 1'b1);
        rx_read_check("R5 rx byte 1");
        rx_read_check("R5 rx byte 2");
        rx_read_check("R4 empty read");
        rx_read_check("R4 empty read again");

        // R6: bad stop bit dropped, next good frame kept
        line_rx(8'h77, 1'b0);
        line_rx(8'h81, 1'b1);
        rx_read_check("R6 good after bad");
        rx_read_check("R6 bad frame absent");

        // R7: short glitch
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (3 * bitp) @(negedge clk);
        rx_read_check("R7 glitch ignored");

        // R9 R10: receive watermark 1
        reg_wr(A_RXC, 32'h1 << 16);
        reg_wr(A_IE, 32'h2);
        line_rx(8'h11, 1'b1);
        reg_rd(A_IP, d); check(d[1] == 1'b0, "R9 one byte not above", d, 32'h0);
        line_rx(8'h22, 1'b1);
        reg_rd(A_IP, d); check(d[1] == 1'b1, "R9 two bytes above", d, 32'h2);
        check(irq == 1'b1, "R10 rx irq", {31'h0, irq}, 32'h1);
        rx_read_check("R9 drain 1");
        rx_read_check("R9 drain 2");
        reg_rd(A_IP, d); check(d[1] == 1'b0, "R9 cleared", d, 32'h0);
        reg_wr(A_IE, 32'h0);
        reg_wr(A_RXC, 32'h0);

        // R12: receive overflow keeps first DEPTH bytes
        for (int i = 0; i < DEPTH + 2; i++) line_rx(8'h40 + 8'(i), 1'b1);
        for (int i = 0; i < DEPTH + 1; i++) rx_read_check("R12 overflow order");

        // R13: slower divisor for both directions
        reg_wr(A_DIV, 32'd31);
        reg_rd(A_DIV, d); check(d == 32'd31, "R13 divisor readback", d, 32'd31);
        bitp = 32;
        mon_have = 0;
        send_byte(8'h9D); send_byte(8'h62); wait_tx_drain();
        check(mon_gap == 10 * bitp + 1, "R13 tx bit period", mon_gap, 10 * bitp + 1);
        line_rx(8'hE7, 1'b1);
        rx_read_check("R13 rx at new rate");

        repeat (10) @(negedge clk);
        check(tx_exp.size() == 0, "R1 all frames seen", tx_exp.size(), 0);
        finish_run();
    end
endmodule